// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the memory-mapped register front end of an interrupt redirection controller. Software reaches every internal register through two 32-bit locations in a small address range: a select location that latches a register index, and a window location through which the indexed register is read or written. Behind the window sit a 4-bit identification register, a read-only version register, an arbitration register, and a table of 64-bit redirection entries, one per interrupt pin, each reached as two 32-bit halves.

Table writes produce side effects toward the servicing logic. A write that flips an entry's mask bit produces a one-cycle notification carrying the pin and the new mask value. A write to a level-triggered entry whose pin has a pending request produces a one-cycle service request for that pin. The servicing logic sets an entry's remote-IRR bit through a per-pin pulse input, and software clears it by writing the lower half of the entry.

A three-state machine sequences each access. In `ST_IDLE` the block is ready and accepts one request. An accepted, valid, in-range table write moves it to `ST_SIDE`. Every other accepted request moves it straight to `ST_RESP`. `ST_SIDE` drives the side-effect strobes and always moves to `ST_RESP`. `ST_RESP` presents the response for one cycle and always returns to `ST_IDLE`.

Top module: `irq_redir_window`

## Requirements
- R1: After reset, the select register reads 0, the identification register reads 0, and every table entry reads with only its mask bit (bit 16 of the lower half) set.
- R2: A 4- or 8-byte write to offset 0x00 latches `bus_wdata[7:0]` as the select value. A read of offset 0x00 returns that value zero-extended.
- R3: With select 0x01, a window read returns the pin count minus one in bits 23:16 and the `VERSION` parameter in bits 7:0, with all other bits zero. Window writes with select 0x01 change nothing.
- R4: With select 0x00, a window write stores `bus_wdata[27:24]` as the identification value, and a window read returns it in bits 27:24. With select 0x02, a window read returns the same value and a window write changes nothing.
- R5: A select value S of 0x10 or above addresses table entry (S-0x10)>>1. An odd S reaches bits 63:32 and an even S reaches bits 31:0. Within the lower half, bit 14 is remote-IRR, bit 15 is the trigger mode (1 = level) and bit 16 is the mask.
- R6: A pulse on `rirr_set_i[p]` sets entry p's remote-IRR bit. A write to the lower half stores the written word but leaves bit 14 clear. A write to the upper half leaves bit 14 unchanged.
- R7: A window write whose computed entry index is at or beyond `NUM_PINS` changes nothing. A window read with such an index, or with an undefined select value (0x03 to 0x0F), returns 0.
- R8: When a table write changes an entry's mask bit, `mask_chg_valid` pulses for one cycle, one cycle after acceptance, with the entry's pin and the new mask value. No pulse occurs otherwise.
- R9: After a table write, if the entry's trigger bit is 1 and `irr_i` for that pin is 1, `svc_req_valid` pulses with that pin in the same cycle as any mask notification. No pulse occurs for an edge-mode entry.
- R10: An access outside [`BASE_ADDR`, `BASE_ADDR`+`SPAN`) is answered with `rsp_claimed`=0 and data 0, and changes no state. Claimed offsets other than 0x00 and 0x10 read 0.
- R11: Writes whose `bus_len` is neither 4 nor 8 are claimed but change nothing.
- R12: `bus_ready` is high only in `ST_IDLE`. `rsp_valid` pulses one cycle after acceptance, or two cycles after acceptance for an in-range valid table write. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted when high together with bus_valid |
| rsp_valid | output | 1 | Response strobe |
| rsp_claimed | output | 1 | Address fell inside the block's range |
| rsp_rdata | output | 32 | Read data |
| irr_i | input | NUM_PINS | Per-pin pending request bits |
| rirr_set_i | input | NUM_PINS | Per-pin pulses that set remote-IRR |
| mask_chg_valid | output | 1 | Mask-change notification strobe |
| mask_chg_pin | output | PIN_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_req_valid | output | 1 | Re-evaluation request strobe |
| svc_req_pin | output | PIN_W | Pin to re-evaluate |

## Verification
The bench probes the last legal entry against the first illegal index, 0x3F against 0x40. A design with an off-by-one in the range check would either drop a write to pin 23 or corrupt storage on a write to index 24. It sets remote-IRR and then writes each half separately, so a design that clears the bit on the wrong half, or never clears it, reads back the wrong word. It checks that mask notifications fire only when the mask bit actually flips, and that service requests require both the level trigger and a pending request. A design that strobes on every table write, or that ignores the trigger mode, shows a spurious pulse. It also checks that ignored accesses (writes to version and arbitration, unclaimed addresses, and 2-byte writes) leave readable state untouched. A decoder that lets any of these through would alter the identification value or the select value.

// File: rtl/irw_pkg.sv
package irw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SIDE = 2'd1,
        ST_RESP = 2'd2
    } irw_state_e;

    localparam int SEL_W = 8;

    // select codes decoded by the window
    localparam logic [SEL_W-1:0] SEL_IDENT = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VERS  = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARBIT = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TABLE = 8'h10;

    // register offsets inside the block's range
    localparam int OFF_SELECT = 'h00;
    localparam int OFF_WINDOW = 'h10;

    // entry field positions the servicing logic decodes
    localparam int F_RIRR = 14;
    localparam int F_TRIG = 15;
    localparam int F_MASK = 16;

    localparam logic [63:0] ENTRY_RESET = 64'(1) << F_MASK;

endpackage

// File: rtl/irw_decode.sv
module irw_decode #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                SPAN      = 256
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              at_sel,
    output logic              at_win
);
    import irw_pkg::*;

    localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(SPAN);

    logic [ADDR_W:0]   a_ext;
    logic [ADDR_W-1:0] off;

    always_comb begin
        a_ext  = {1'b0, addr};
        off    = addr - BASE_ADDR;
        hit    = (a_ext >= LO) && (a_ext < HI);
        at_sel = hit && (off == ADDR_W'(OFF_SELECT));
        at_win = hit && (off == ADDR_W'(OFF_WINDOW));
    end

endmodule

// File: rtl/irw_index.sv
module irw_index #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic [irw_pkg::SEL_W-1:0] sel,
    output logic                      is_tbl,
    output logic                      upper,
    output logic                      idx_ok,
    output logic [PIN_W-1:0]          pin
);
    import irw_pkg::*;

    localparam int IDX_W = SEL_W - 1;

    logic [SEL_W-1:0] rel;
    logic [IDX_W-1:0] idx;

    always_comb begin
        rel    = sel - SEL_TABLE;
        idx    = rel[SEL_W-1:1];
        upper  = rel[0];
        is_tbl = (sel >= SEL_TABLE);
        idx_ok = is_tbl && (32'(idx) < 32'(NUM_PINS));
        pin    = idx[PIN_W-1:0];
    end

endmodule

// File: rtl/irw_table.sv
module irw_table #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PIN_W-1:0]             wr_pin,
    input  logic                         wr_hi,
    input  logic [31:0]                  wr_data,
    input  logic [NUM_PINS-1:0]          rirr_set,
    output logic [NUM_PINS-1:0][63:0]    ent_o
);
    import irw_pkg::*;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [63:0] ent_r;
        logic        hit_w;

        assign hit_w    = wr_en && (wr_pin == PIN_W'(p));
        assign ent_o[p] = ent_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_r <= ENTRY_RESET;
            end else begin
                if (rirr_set[p]) begin
                    ent_r[F_RIRR] <= 1'b1;
                end
                if (hit_w) begin
                    if (wr_hi) begin
                        ent_r[63:32] <= wr_data;
                    end else begin
                        ent_r[31:0]   <= wr_data;
                        ent_r[F_RIRR] <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window #(
    parameter int                NUM_PINS  = 24,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFEC0_0000,
    parameter int                SPAN      = 256,
    parameter logic [7:0]        VERSION   = 8'h11,
    localparam int               PIN_W     = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_len,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ready,
    output logic                rsp_valid,
    output logic                rsp_claimed,
    output logic [31:0]         rsp_rdata,
    input  logic [NUM_PINS-1:0] irr_i,
    input  logic [NUM_PINS-1:0] rirr_set_i,
    output logic                mask_chg_valid,
    output logic [PIN_W-1:0]    mask_chg_pin,
    output logic                mask_chg_val,
    output logic                svc_req_valid,
    output logic [PIN_W-1:0]    svc_req_pin
);
    import irw_pkg::*;

    localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

    irw_state_e state_q, state_d;

    logic [SEL_W-1:0]            sel_q;
    logic [3:0]                  ident_q;
    logic                        claim_q;
    logic [31:0]                 data_q;
    logic [PIN_W-1:0]            pin_q;
    logic                        old_mask_q;

    logic                        hit, at_sel, at_win;
    logic                        is_tbl, upper, idx_ok;
    logic [PIN_W-1:0]            pin;
    logic [NUM_PINS-1:0][63:0]   ent;

    logic                        accept;
    logic                        len_ok;
    logic                        reg_wr;
    logic                        tbl_wr;
    logic [31:0]                 rd_word;

    irw_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .SPAN      (SPAN)
    ) u_decode (
        .addr   (bus_addr),
        .hit    (hit),
        .at_sel (at_sel),
        .at_win (at_win)
    );

    irw_index #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_index (
        .sel    (sel_q),
        .is_tbl (is_tbl),
        .upper  (upper),
        .idx_ok (idx_ok),
        .pin    (pin)
    );

    irw_table #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_pin   (pin),
        .wr_hi    (upper),
        .wr_data  (bus_wdata),
        .rirr_set (rirr_set_i),
        .ent_o    (ent)
    );

    // request qualification
    always_comb begin
        accept = bus_valid && (state_q == ST_IDLE);
        len_ok = (bus_len == 4'd4) || (bus_len == 4'd8);
        reg_wr = accept && bus_write && len_ok && hit;
        tbl_wr = reg_wr && at_win && idx_ok;
    end

    // read data selection
    always_comb begin
        rd_word = '0;
        if (at_sel) begin
            rd_word = {{(32-SEL_W){1'b0}}, sel_q};
        end else if (at_win) begin
            if (sel_q == SEL_IDENT || sel_q == SEL_ARBIT) begin
                rd_word = {4'h0, ident_q, 24'h0};
            end else if (sel_q == SEL_VERS) begin
                rd_word = {8'h00, PIN_MAX, 8'h00, VERSION};
            end else if (is_tbl && idx_ok) begin
                rd_word = upper ? ent[pin][63:32] : ent[pin][31:0];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tbl_wr) begin
                    state_d = ST_SIDE;
                end else if (accept) begin
                    state_d = ST_RESP;
                end
            end
            ST_SIDE: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '0;
            ident_q    <= '0;
            claim_q    <= 1'b0;
            data_q     <= '0;
            pin_q      <= '0;
            old_mask_q <= 1'b0;
        end else begin
            if (accept) begin
                claim_q <= hit;
                data_q  <= bus_write ? 32'h0 : rd_word;
            end
            if (reg_wr && at_sel) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
            if (reg_wr && at_win && sel_q == SEL_IDENT) begin
                ident_q <= bus_wdata[27:24];
            end
            if (tbl_wr) begin
                pin_q      <= pin;
                old_mask_q <= ent[pin][F_MASK];
            end
        end
    end

    // outputs
    always_comb begin
        bus_ready      = (state_q == ST_IDLE);
        rsp_valid      = (state_q == ST_RESP);
        rsp_claimed    = rsp_valid && claim_q;
        rsp_rdata      = rsp_valid ? data_q : 32'h0;
        mask_chg_pin   = pin_q;
        mask_chg_val   = ent[pin_q][F_MASK];
        mask_chg_valid = (state_q == ST_SIDE) && (ent[pin_q][F_MASK] != old_mask_q);
        svc_req_pin    = pin_q;
        svc_req_valid  = (state_q == ST_SIDE) && ent[pin_q][F_TRIG] && irr_i[pin_q];
    end

endmodule

// File: rtl/irw_chk.sv
module irw_chk #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             bus_ready,
    input logic             rsp_valid,
    input logic             rsp_claimed,
    input logic [31:0]      rsp_rdata,
    input logic             mask_chg_valid,
    input logic [PIN_W-1:0] mask_chg_pin,
    input logic             svc_req_valid
);

    p_resp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> !bus_ready);

    p_unclaimed_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claimed) |-> (rsp_rdata == 32'h0));

    p_mask_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> $past(bus_valid && bus_ready && bus_write));

    p_mask_pin_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (32'(mask_chg_pin) < 32'(NUM_PINS)));

    p_svc_then_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_valid |=> rsp_valid);

endmodule

bind irq_redir_window irw_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) u_irw_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_ready      (bus_ready),
    .rsp_valid      (rsp_valid),
    .rsp_claimed    (rsp_claimed),
    .rsp_rdata      (rsp_rdata),
    .mask_chg_valid (mask_chg_valid),
    .mask_chg_pin   (mask_chg_pin),
    .svc_req_valid  (svc_req_valid)
);

// File: tb/tb_irq_redir_window.sv
`timescale 1ns/1ps
module tb_irq_redir_window;

    localparam int          NP    = 24;
    localparam int          PW    = $clog2(NP);
    localparam logic [31:0] A_SEL = 32'hFEC0_0000;
    localparam logic [31:0] A_WIN = 32'hFEC0_0010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [3:0]    bus_len = 4'd4;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready;
    logic          rsp_valid;
    logic          rsp_claimed;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] irr_i = '0;
    logic [NP-1:0] rirr_set_i = '0;
    logic          mask_chg_valid;
    logic [PW-1:0] mask_chg_pin;
    logic          mask_chg_val;
    logic          svc_req_valid;
    logic [PW-1:0] svc_req_pin;

    always #4 clk = ~clk;

    irq_redir_window dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .rsp_valid(rsp_valid), .rsp_claimed(rsp_claimed),
        .rsp_rdata(rsp_rdata), .irr_i(irr_i), .rirr_set_i(rirr_set_i),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_val(mask_chg_val), .svc_req_valid(svc_req_valid),
        .svc_req_pin(svc_req_pin)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    // results of the last transfer
    logic          r_claim;
    logic [31:0]   r_data;
    int            r_lat;
    bit            seen_mask, seen_svc;
    logic [PW-1:0] seen_mpin, seen_spin;
    logic          seen_mval;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  len;
        logic [31:0] data;
        logic        claim;
        logic [31:0] exp;
        logic [1:0]  lat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_SEL, 4'd4, 32'h0, 1'b1, 32'h0, 2'd1, 4'd1},               // R1 select reset
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0, 2'd1, 4'd1},               // R1 ident reset
        '{1'b1, A_SEL, 4'd4, 32'h01, 1'b1, 32'h0, 2'd1, 4'd2},              // R2
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0017_0011, 2'd1, 4'd3},       // R3
        '{1'b1, A_WIN, 4'd4, 32'hFFFF_FFFF, 1'b1, 32'h0, 2'd1, 4'd3},       // R3 ignored write
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0017_0011, 2'd1, 4'd3},       // R3
        '{1'b1, A_SEL, 4'd4, 32'h00, 1'b1, 32'h0, 2'd1, 4'd2},              // R2
        '{1'b1, A_WIN, 4'd8, 32'h0A00_0000, 1'b1, 32'h0, 2'd1, 4'd4},       // R4 8-byte write
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0A00_0000, 2'd1, 4'd4},       // R4
        '{1'b1, A_SEL, 4'd4, 32'h02, 1'b1, 32'h0, 2'd1, 4'd2},              // R2
        '{1'b1, A_WIN, 4'd4, 32'h0500_0000, 1'b1, 32'h0, 2'd1, 4'd4},       // R4 arbitration write
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0A00_0000, 2'd1, 4'd4},       // R4
        '{1'b1, A_SEL, 4'd4, 32'h10, 1'b1, 32'h0, 2'd1, 4'd2},              // R2
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0001_0000, 2'd1, 4'd1},       // R1 mask set
        '{1'b1, A_SEL, 4'd4, 32'h3F, 1'b1, 32'h0, 2'd1, 4'd5},              // R5 last pin upper
        '{1'b1, A_WIN, 4'd4, 32'hAB00_0000, 1'b1, 32'h0, 2'd2, 4'd12},      // R12 table write latency
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'hAB00_0000, 2'd1, 4'd5},       // R5
        '{1'b1, A_SEL, 4'd4, 32'h3E, 1'b1, 32'h0, 2'd1, 4'd5},              // R5
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0001_0000, 2'd1, 4'd5},       // R5 lower half apart
        '{1'b1, A_SEL, 4'd4, 32'h40, 1'b1, 32'h0, 2'd1, 4'd7},              // R7 index 24
        '{1'b1, A_WIN, 4'd4, 32'h1234_5678, 1'b1, 32'h0, 2'd1, 4'd7},       // R7 ignored
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0, 2'd1, 4'd7},               // R7 reads 0
        '{1'b0, A_SEL, 4'd4, 32'h0, 1'b1, 32'h40, 2'd1, 4'd2},              // R2 readback
        '{1'b1, A_SEL, 4'd4, 32'h03, 1'b1, 32'h0, 2'd1, 4'd7},              // R7
        '{1'b0, A_WIN, 4'd4, 32'h0, 1'b1, 32'h0, 2'd1, 4'd7},               // R7 undefined select
        '{1'b0, A_SEL + 32'h20, 4'd4, 32'h0, 1'b1, 32'h0, 2'd1, 4'd10},     // R10 other offset
        '{1'b0, A_SEL - 32'h4, 4'd4, 32'h0, 1'b0, 32'h0, 2'd1, 4'd10},      // R10 below range
        '{1'b1, A_SEL + 32'h100, 4'd4, 32'h77, 1'b0, 32'h0, 2'd1, 4'd10},   // R10 above range
        '{1'b1, A_SEL, 4'd2, 32'h55, 1'b1, 32'h0, 2'd1, 4'd11},             // R11 short write
        '{1'b0, A_SEL, 4'd4, 32'h0, 1'b1, 32'h03, 2'd1, 4'd11},             // R11 unchanged
        '{1'b1, A_SEL - 32'h4, 4'd4, 32'h66, 1'b0, 32'h0, 2'd1, 4'd10},     // R10 unclaimed write
        '{1'b0, A_SEL, 4'd4, 32'h0, 1'b1, 32'h03, 2'd1, 4'd10}              // R10 unchanged
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [31:0] a, input logic [3:0] l,
                        input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_len = l; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        seen_mask = 1'b0; seen_svc = 1'b0; r_lat = 1;
        while (!rsp_valid) begin
            if (mask_chg_valid) begin
                seen_mask = 1'b1; seen_mpin = mask_chg_pin; seen_mval = mask_chg_val;
            end
            if (svc_req_valid) begin
                seen_svc = 1'b1; seen_spin = svc_req_pin;
            end
            @(negedge clk);
            r_lat++;
        end
        r_claim = rsp_claimed;
        r_data  = rsp_rdata;
    endtask

    task automatic rd_sel(input logic [7:0] s, input string tag, input logic [31:0] exp);
        xfer(1'b1, A_SEL, 4'd4, {24'h0, s});
        xfer(1'b0, A_WIN, 4'd4, 32'h0);
        chk(r_data == exp, tag, r_data, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_ready == 1'b1, "R12 ready after reset", 32'(bus_ready), 32'h1);

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].len, VECS[i].data);
            chk(r_claim == VECS[i].claim, $sformatf("R%0d row %0d claim", VECS[i].req, i),
                32'(r_claim), 32'(VECS[i].claim));
            chk(r_data == VECS[i].exp, $sformatf("R%0d row %0d data", VECS[i].req, i),
                r_data, VECS[i].exp);
            chk(r_lat == int'(VECS[i].lat), $sformatf("R12 row %0d latency", i),
                32'(r_lat), 32'(VECS[i].lat));
        end

        // R6: remote-IRR set, kept by upper write, cleared by lower write (pin 5)
        @(negedge clk); rirr_set_i = NP'(1) << 5;
        @(negedge clk); rirr_set_i = '0;
        rd_sel(8'h1A, "R6 set by pulse", 32'h0001_4000);
        xfer(1'b1, A_SEL, 4'd4, 32'h1B);
        xfer(1'b1, A_WIN, 4'd4, 32'h0300_0000);
        chk(!seen_mask, "R8 no mask event on upper write", 32'(seen_mask), 32'h0);
        rd_sel(8'h1A, "R6 upper write keeps bit", 32'h0001_4000);
        xfer(1'b1, A_WIN - 32'h10, 4'd4, 32'h1A);
        xfer(1'b1, A_WIN, 4'd4, 32'h0000_E031);
        chk(seen_mask && seen_mpin == PW'(5) && seen_mval == 1'b0, "R8 unmask event",
            {seen_mask, 23'h0, 3'h0, seen_mval, 3'(seen_mpin)}, {1'b1, 23'h0, 3'h0, 1'b0, 3'd5});
        chk(!seen_svc, "R9 no request without pending", 32'(seen_svc), 32'h0);
        xfer(1'b0, A_WIN, 4'd4, 32'h0);
        chk(r_data == 32'h0000_A031, "R6 lower write clears", r_data, 32'h0000_A031);

        // R9: level entry with pending request
        irr_i = NP'(1) << 5;
        xfer(1'b1, A_SEL, 4'd4, 32'h1B);
        xfer(1'b1, A_WIN, 4'd4, 32'h0300_0000);
        chk(seen_svc && seen_spin == PW'(5), "R9 level pending request",
            32'(seen_svc), 32'h1);
        chk(!seen_mask, "R8 no event when mask steady", 32'(seen_mask), 32'h0);
        xfer(1'b1, A_SEL, 4'd4, 32'h1A);
        xfer(1'b1, A_WIN, 4'd4, 32'h0000_0031);
        chk(!seen_svc, "R9 edge entry no request", 32'(seen_svc), 32'h0);
        xfer(1'b1, A_WIN, 4'd4, 32'h0001_8031);
        chk(seen_mask && seen_mval == 1'b1, "R8 mask event", 32'(seen_mval), 32'h1);
        chk(seen_svc && seen_spin == PW'(5), "R9 request with mask flip", 32'(seen_svc), 32'h1);
        irr_i = '0;

        // R1: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        xfer(1'b0, A_SEL, 4'd4, 32'h0);
        chk(r_data == 32'h0, "R1 select after reset", r_data, 32'h0);
        rd_sel(8'h1A, "R1 mask after reset", 32'h0001_0000);
        rd_sel(8'h00, "R1 ident after reset", 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule